// File: doc/BRIEF.md
# Pipeline Hazard and Operand Bypass Control

This block is the hazard control for a five-stage in-order integer pipeline (fetch, decode/register read, execute, memory, write-back). Conditional branches are resolved in decode: an equality comparator there looks at the two source operands, and the target is computed in the same stage. The block watches the register fields and control bits held in the stage registers. From them it chooses where each execute-stage operand and each decode-stage comparator operand comes from. It also decides when the front of the pipe must hold, and when the instruction fetched behind a taken branch must be squashed.

The block is purely combinational. The datapath registers its outputs.

- A hold means the datapath keeps the PC and the fetch/decode register, and loads an all-zero control bundle into the decode/execute register.
- A squash means the fetch/decode register is turned into a no-op, and the PC is loaded with the branch target.

Fetch always assumes a branch is not taken. Instruction and data memories are separate, so there is no structural hold. The register file writes in the first half of a cycle and is read in the second half, so a value retiring from write-back is already visible to decode.

Top module: `hazard_fwd_unit`

## Requirements
- R1: Each execute operand select is 2'b10 (take the memory-stage result) when the memory stage writes a nonzero register equal to that source. Otherwise it is 2'b01 (take the write-back result) when write-back writes a nonzero register equal to that source. Otherwise it is 2'b00 (keep the register-file value). The memory stage wins when both match.
- R2: Register 0 is never a bypass source: a source or destination field of 0 gives select 0 on every operand path.
- R3: `stall` is 1 when the execute stage holds a load that writes a nonzero register equal to a source that decode uses (`id_use_rs`/`id_use_rt`). A source that is not used never causes a hold.
- R4: An arithmetic result in execute, consumed by a non-branch instruction in decode, causes no hold. With no hazard condition present, `stall` and `flush` are 0; all-zero inputs give all-zero outputs.
- R5: A branch in decode holds while the execute stage writes a nonzero register equal to a used branch source, whether or not that producer is a load.
- R6: A branch in decode holds while the memory stage holds a load writing a used branch source. A non-load result in the memory stage causes no hold. A load directly ahead of a dependent branch therefore holds the branch for exactly two cycles.
- R7: Each decode comparator select is 1 (take the memory-stage result) when the memory stage writes a nonzero register equal to that source, and 0 (register-file value) otherwise. A write-back match alone gives 0.
- R8: `flush` is 1 exactly when decode holds a branch, its compare reports equal, and `stall` is 0. A hold takes priority over the squash.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| id_rs | input | REG_W | First source register of the decode instruction |
| id_rt | input | REG_W | Second source register of the decode instruction |
| id_use_rs | input | 1 | Decode instruction reads id_rs |
| id_use_rt | input | 1 | Decode instruction reads id_rt |
| id_is_branch | input | 1 | Decode instruction is a conditional branch |
| id_br_eq | input | 1 | Decode comparator reports equal operands (branch taken) |
| ex_rs | input | REG_W | First source register held in decode/execute |
| ex_rt | input | REG_W | Second source register held in decode/execute |
| ex_rd | input | REG_W | Destination register held in decode/execute |
| ex_reg_we | input | 1 | Execute instruction writes a register |
| ex_is_load | input | 1 | Execute instruction is a load |
| mem_rd | input | REG_W | Destination register held in execute/memory |
| mem_reg_we | input | 1 | Memory-stage instruction writes a register |
| mem_is_load | input | 1 | Memory-stage instruction is a load |
| wb_rd | input | REG_W | Destination register held in memory/write-back |
| wb_reg_we | input | 1 | Write-back instruction writes a register |
| ex_fwd_a | output | 2 | Execute first operand select (00 file, 01 write-back, 10 memory stage) |
| ex_fwd_b | output | 2 | Execute second operand select, same coding |
| id_fwd_a | output | 1 | Comparator first operand: 1 memory-stage result, 0 file |
| id_fwd_b | output | 1 | Comparator second operand, same coding |
| stall | output | 1 | Hold PC and fetch/decode, bubble into decode/execute |
| flush | output | 1 | Squash fetch/decode and redirect to branch target |

## Verification
The hardest situation to reach is a branch whose operand comes from a load directly ahead of it. To exercise it, the stage fields must evolve as a real pipe would move them: the load sits in execute, then in memory with a bubble behind it, then in write-back. At each step the hold must be present, present, then gone, with the comparator selecting the register file. The bench replays that walk and the arithmetic-producer variant as directed cycle-by-cycle sequences. It then runs a long constrained-random phase with register numbers drawn from a small range, so that source/destination coincidences, double matches and register 0 occur often. Expected outputs come from bench functions written from the requirements.

// File: rtl/hzu_pkg.sv
package hzu_pkg;

    localparam int SEL_W = 2;

    typedef enum logic [SEL_W-1:0] {
        SEL_FILE = 2'b00,
        SEL_WB   = 2'b01,
        SEL_MEM  = 2'b10
    } byp_sel_e;

    typedef struct packed {
        logic stall;
        logic flush;
    } pipe_ctl_t;

endpackage

// File: rtl/hz_ex_bypass.sv
module hz_ex_bypass
    import hzu_pkg::*;
#(
    parameter int REG_W = 5,
    parameter int N_SRC = 2
) (
    input  logic [N_SRC-1:0][REG_W-1:0] src,
    input  logic [REG_W-1:0]            mem_rd,
    input  logic                        mem_we,
    input  logic [REG_W-1:0]            wb_rd,
    input  logic                        wb_we,
    output logic [N_SRC-1:0][SEL_W-1:0] sel
);

    localparam logic [REG_W-1:0] ZERO_REG = '0;

    logic mem_live;
    logic wb_live;

    assign mem_live = mem_we && (mem_rd != ZERO_REG);
    assign wb_live  = wb_we && (wb_rd != ZERO_REG);

    for (genvar g = 0; g < N_SRC; g++) begin : g_op
        logic [SEL_W-1:0] sel_d;

        always_comb begin
            sel_d = SEL_FILE;
            if (mem_live && (mem_rd == src[g])) begin
                sel_d = SEL_MEM;
            end else if (wb_live && (wb_rd == src[g])) begin
                sel_d = SEL_WB;
            end
        end

        assign sel[g] = sel_d;

        always_comb begin
            if (!$isunknown(sel[g])) begin
                p_sel_code_legal_r1 : assert (sel[g] != 2'b11)
                    else $error("execute select uses reserved code");
            end
        end
    end

endmodule

// File: rtl/hz_id_bypass.sv
module hz_id_bypass #(
    parameter int REG_W = 5,
    parameter int N_SRC = 2
) (
    input  logic [N_SRC-1:0][REG_W-1:0] src,
    input  logic [REG_W-1:0]            mem_rd,
    input  logic                        mem_we,
    output logic [N_SRC-1:0]            sel
);

    localparam logic [REG_W-1:0] ZERO_REG = '0;

    logic mem_live;
    assign mem_live = mem_we && (mem_rd != ZERO_REG);

    for (genvar g = 0; g < N_SRC; g++) begin : g_op
        logic sel_d;

        always_comb begin
            sel_d = mem_live && (mem_rd == src[g]);
        end

        assign sel[g] = sel_d;
    end

endmodule

// File: rtl/hz_stall_ctl.sv
module hz_stall_ctl
    import hzu_pkg::*;
#(
    parameter int REG_W = 5,
    parameter int N_SRC = 2
) (
    input  logic [N_SRC-1:0][REG_W-1:0] src,
    input  logic [N_SRC-1:0]            use_src,
    input  logic                        is_branch,
    input  logic                        br_eq,
    input  logic [REG_W-1:0]            ex_rd,
    input  logic                        ex_we,
    input  logic                        ex_ld,
    input  logic [REG_W-1:0]            mem_rd,
    input  logic                        mem_we,
    input  logic                        mem_ld,
    output logic                        stall,
    output logic                        flush
);

    localparam logic [REG_W-1:0] ZERO_REG = '0;

    logic [N_SRC-1:0] ex_hit;
    logic [N_SRC-1:0] mem_hit;
    pipe_ctl_t        ctl_d;

    for (genvar g = 0; g < N_SRC; g++) begin : g_hit
        assign ex_hit[g]  = use_src[g] && ex_we && (ex_rd != ZERO_REG)
                            && (ex_rd == src[g]);
        assign mem_hit[g] = use_src[g] && mem_we && (mem_rd != ZERO_REG)
                            && (mem_rd == src[g]);
    end

    always_comb begin
        logic load_use;
        logic br_wait_ex;
        logic br_wait_mem;
        load_use    = ex_ld && (|ex_hit);
        br_wait_ex  = is_branch && (|ex_hit);
        br_wait_mem = is_branch && mem_ld && (|mem_hit);
        ctl_d.stall = load_use || br_wait_ex || br_wait_mem;
        ctl_d.flush = is_branch && br_eq && !ctl_d.stall;
    end

    assign stall = ctl_d.stall;
    assign flush = ctl_d.flush;

    always_comb begin
        if (!$isunknown({ex_hit, ex_ld, stall})) begin
            p_load_use_holds_r3 : assert (!(ex_ld && (|ex_hit)) || stall)
                else $error("load-use hazard without hold");
        end
    end

endmodule

// File: rtl/hazard_fwd_unit.sv
module hazard_fwd_unit
    import hzu_pkg::*;
#(
    parameter int REG_W = 5
) (
    input  logic [REG_W-1:0] id_rs,
    input  logic [REG_W-1:0] id_rt,
    input  logic             id_use_rs,
    input  logic             id_use_rt,
    input  logic             id_is_branch,
    input  logic             id_br_eq,
    input  logic [REG_W-1:0] ex_rs,
    input  logic [REG_W-1:0] ex_rt,
    input  logic [REG_W-1:0] ex_rd,
    input  logic             ex_reg_we,
    input  logic             ex_is_load,
    input  logic [REG_W-1:0] mem_rd,
    input  logic             mem_reg_we,
    input  logic             mem_is_load,
    input  logic [REG_W-1:0] wb_rd,
    input  logic             wb_reg_we,
    output logic [1:0]       ex_fwd_a,
    output logic [1:0]       ex_fwd_b,
    output logic             id_fwd_a,
    output logic             id_fwd_b,
    output logic             stall,
    output logic             flush
);

    localparam int N_SRC = 2;

    logic [N_SRC-1:0][REG_W-1:0] id_src;
    logic [N_SRC-1:0][REG_W-1:0] ex_src;
    logic [N_SRC-1:0]            id_use;
    logic [N_SRC-1:0][SEL_W-1:0] ex_sel;
    logic [N_SRC-1:0]            id_sel;

    assign id_src = {id_rt, id_rs};
    assign ex_src = {ex_rt, ex_rs};
    assign id_use = {id_use_rt, id_use_rs};

    hz_ex_bypass #(.REG_W(REG_W), .N_SRC(N_SRC)) u_ex_byp (
        .src    (ex_src),
        .mem_rd (mem_rd),
        .mem_we (mem_reg_we),
        .wb_rd  (wb_rd),
        .wb_we  (wb_reg_we),
        .sel    (ex_sel)
    );

    hz_id_bypass #(.REG_W(REG_W), .N_SRC(N_SRC)) u_id_byp (
        .src    (id_src),
        .mem_rd (mem_rd),
        .mem_we (mem_reg_we),
        .sel    (id_sel)
    );

    hz_stall_ctl #(.REG_W(REG_W), .N_SRC(N_SRC)) u_ctl (
        .src       (id_src),
        .use_src   (id_use),
        .is_branch (id_is_branch),
        .br_eq     (id_br_eq),
        .ex_rd     (ex_rd),
        .ex_we     (ex_reg_we),
        .ex_ld     (ex_is_load),
        .mem_rd    (mem_rd),
        .mem_we    (mem_reg_we),
        .mem_ld    (mem_is_load),
        .stall     (stall),
        .flush     (flush)
    );

    assign ex_fwd_a = ex_sel[0];
    assign ex_fwd_b = ex_sel[1];
    assign id_fwd_a = id_sel[0];
    assign id_fwd_b = id_sel[1];

    always_comb begin
        if (!$isunknown({stall, flush})) begin
            p_hold_beats_squash_r8 : assert (!(stall && flush))
                else $error("squash issued during hold");
        end
        if (!$isunknown({ex_rs, ex_fwd_a})) begin
            p_zero_never_bypassed_r2 : assert ((ex_rs != '0) || (ex_fwd_a == SEL_FILE))
                else $error("register 0 bypassed");
        end
        if (!$isunknown({id_is_branch, id_use_rs, id_fwd_a, mem_is_load, stall})) begin
            p_branch_waits_load_r6 : assert (!(id_is_branch && id_use_rs && id_fwd_a
                                               && mem_is_load) || stall)
                else $error("branch took a load address as operand");
        end
        if (!$isunknown({id_is_branch, id_use_rt, id_rt, ex_rd, ex_reg_we, stall})) begin
            p_branch_waits_ex_r5 : assert (!(id_is_branch && id_use_rt && ex_reg_we
                                             && (ex_rd != '0) && (ex_rd == id_rt)) || stall)
                else $error("branch compared before execute result existed");
        end
    end

endmodule

// File: tb/sim_hazard_fwd_unit.sv
module sim_hazard_fwd_unit;

    localparam int RW = 5;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic [RW-1:0] id_rs, id_rt, ex_rs, ex_rt, ex_rd, mem_rd, wb_rd;
    logic id_use_rs, id_use_rt, id_is_branch, id_br_eq;
    logic ex_reg_we, ex_is_load, mem_reg_we, mem_is_load, wb_reg_we;
    logic [1:0] ex_fwd_a, ex_fwd_b;
    logic id_fwd_a, id_fwd_b, stall, flush;

    int checks = 0;
    int failures = 0;

    hazard_fwd_unit #(.REG_W(RW)) u0 (
        .id_rs(id_rs), .id_rt(id_rt), .id_use_rs(id_use_rs), .id_use_rt(id_use_rt),
        .id_is_branch(id_is_branch), .id_br_eq(id_br_eq),
        .ex_rs(ex_rs), .ex_rt(ex_rt), .ex_rd(ex_rd), .ex_reg_we(ex_reg_we),
        .ex_is_load(ex_is_load), .mem_rd(mem_rd), .mem_reg_we(mem_reg_we),
        .mem_is_load(mem_is_load), .wb_rd(wb_rd), .wb_reg_we(wb_reg_we),
        .ex_fwd_a(ex_fwd_a), .ex_fwd_b(ex_fwd_b), .id_fwd_a(id_fwd_a),
        .id_fwd_b(id_fwd_b), .stall(stall), .flush(flush)
    );

    // R1/R2: 10 memory stage, 01 write-back, 00 file
    function automatic logic [1:0] want_ex(logic [RW-1:0] s);
        if (mem_reg_we && mem_rd != 0 && mem_rd == s) return 2'b10;
        if (wb_reg_we && wb_rd != 0 && wb_rd == s) return 2'b01;
        return 2'b00;
    endfunction

    // R7
    function automatic logic want_id(logic [RW-1:0] s);
        return mem_reg_we && mem_rd != 0 && mem_rd == s;
    endfunction

    function automatic logic dep(logic [RW-1:0] d, logic we);
        return we && d != 0 &&
               ((id_use_rs && d == id_rs) || (id_use_rt && d == id_rt));
    endfunction

    // R3, R5, R6
    function automatic logic want_stall();
        return (ex_is_load && dep(ex_rd, ex_reg_we)) ||
               (id_is_branch && dep(ex_rd, ex_reg_we)) ||
               (id_is_branch && mem_is_load && dep(mem_rd, mem_reg_we));
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic idle();
        id_rs = 0; id_rt = 0; id_use_rs = 0; id_use_rt = 0;
        id_is_branch = 0; id_br_eq = 0;
        ex_rs = 0; ex_rt = 0; ex_rd = 0; ex_reg_we = 0; ex_is_load = 0;
        mem_rd = 0; mem_reg_we = 0; mem_is_load = 0; wb_rd = 0; wb_reg_we = 0;
    endtask

    task automatic settle();
        @(negedge clk);
        #1;
    endtask

    task automatic check_all(string tag);
        check({tag, " R1 ex_fwd_a"}, 32'(ex_fwd_a), 32'(want_ex(ex_rs)));
        check({tag, " R1 ex_fwd_b"}, 32'(ex_fwd_b), 32'(want_ex(ex_rt)));
        check({tag, " R7 id_fwd_a"}, 32'(id_fwd_a), 32'(want_id(id_rs)));
        check({tag, " R7 id_fwd_b"}, 32'(id_fwd_b), 32'(want_id(id_rt)));
        check({tag, " R3/R5/R6 stall"}, 32'(stall), 32'(want_stall()));
        check({tag, " R8 flush"}, 32'(flush),
              32'(id_is_branch && id_br_eq && !want_stall()));
    endtask

    initial begin
        #(8 * 200000);
        failures++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        idle();
        settle();
        // R4: all-zero inputs, all-zero outputs
        check("R4 idle outputs", {26'd0, ex_fwd_a, ex_fwd_b, id_fwd_a, id_fwd_b, stall, flush}, 32'd0);

        // R1: both later stages write r3, memory stage wins
        idle(); ex_rs = 3; ex_rt = 3; mem_rd = 3; mem_reg_we = 1; wb_rd = 3; wb_reg_we = 1;
        settle();
        check("R1 priority a", 32'(ex_fwd_a), 32'h2);
        wb_rd = 3; mem_rd = 4;
        settle();
        check("R1 write-back only", 32'(ex_fwd_b), 32'h1);

        // R2: register 0 never bypassed
        idle(); ex_rs = 0; mem_rd = 0; mem_reg_we = 1; wb_rd = 0; wb_reg_we = 1; id_rs = 0;
        settle();
        check("R2 ex zero", 32'(ex_fwd_a), 32'h0);
        check("R2 id zero", 32'(id_fwd_a), 32'h0);

        // R3: load r5 in execute, add uses r5
        idle(); ex_rd = 5; ex_reg_we = 1; ex_is_load = 1; id_rt = 5; id_use_rt = 1;
        settle();
        check("R3 load-use stall", 32'(stall), 32'h1);
        id_use_rt = 0;
        settle();
        check("R3 unused source no stall", 32'(stall), 32'h0);

        // R4: arithmetic producer, arithmetic consumer
        idle(); ex_rd = 6; ex_reg_we = 1; id_rs = 6; id_use_rs = 1;
        settle();
        check("R4 alu dep no stall", 32'(stall), 32'h0);

        // R5/R6/R8: load r7 then branch on r7 (taken); walk the stages
        idle(); id_is_branch = 1; id_br_eq = 1; id_rs = 7; id_rt = 2;
        id_use_rs = 1; id_use_rt = 1;
        ex_rd = 7; ex_reg_we = 1; ex_is_load = 1;
        settle();
        check("R5 load in execute stall", 32'(stall), 32'h1);
        check("R8 no flush while held", 32'(flush), 32'h0);
        ex_rd = 0; ex_reg_we = 0; ex_is_load = 0;
        mem_rd = 7; mem_reg_we = 1; mem_is_load = 1;
        settle();
        check("R6 load in memory stall", 32'(stall), 32'h1);
        mem_rd = 0; mem_reg_we = 0; mem_is_load = 0; wb_rd = 7; wb_reg_we = 1;
        settle();
        check("R6 released third cycle", 32'(stall), 32'h0);
        check("R7 file after write-back", 32'(id_fwd_a), 32'h0);
        check("R8 flush on taken", 32'(flush), 32'h1);

        // R5/R6/R7: arithmetic r9 then branch on r9
        idle(); id_is_branch = 1; id_rt = 9; id_use_rs = 1; id_use_rt = 1;
        ex_rd = 9; ex_reg_we = 1;
        settle();
        check("R5 alu in execute stall", 32'(stall), 32'h1);
        ex_rd = 0; ex_reg_we = 0; mem_rd = 9; mem_reg_we = 1;
        settle();
        check("R6 alu in memory no stall", 32'(stall), 32'h0);
        check("R7 comparator bypass", 32'(id_fwd_b), 32'h1);
        check("R8 not taken no flush", 32'(flush), 32'h0);

        // Constrained random: small register range forces coincidences
        for (int i = 0; i < 4000; i++) begin
            id_rs = RW'($urandom_range(0, 3)); id_rt = RW'($urandom_range(0, 3));
            ex_rs = RW'($urandom_range(0, 3)); ex_rt = RW'($urandom_range(0, 3));
            ex_rd = RW'($urandom_range(0, 3)); mem_rd = RW'($urandom_range(0, 3));
            wb_rd = RW'($urandom_range(0, 3));
            id_use_rs = 1'($urandom); id_use_rt = 1'($urandom);
            id_is_branch = 1'($urandom); id_br_eq = 1'($urandom);
            ex_reg_we = 1'($urandom); ex_is_load = ex_reg_we & 1'($urandom);
            mem_reg_we = 1'($urandom); mem_is_load = mem_reg_we & 1'($urandom);
            wb_reg_we = 1'($urandom);
            settle();
            check_all("random");
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule